// File: doc/BRIEF.md
# General-Call Software Reset Detector

This block watches an I2C target's already-decoded bus events (START or repeated START, STOP, a completed byte, and the end of the acknowledge slot). It looks for the general-call software reset sequence. For every byte it decides whether the target should drive an acknowledge. When the whole sequence ends in a STOP, it issues a single-cycle reset pulse to the device's registers.

The accepted sequence has four steps. A START comes first. The write-direction general-call address byte follows and is acknowledged. Then comes exactly one command byte equal to 06h, which is also acknowledged. A STOP ends the sequence. Any deviation aborts the attempt and leaves the detector silent until the next START. Deviations include:
- a read-direction general call,
- another address,
- a wrong command,
- a surplus byte,
- a repeated START in place of the STOP.

The bit-level engine that samples SCL and SDA feeds the event inputs. It reads `ack_req` while the acknowledge bit is on the bus.

Top module: `gc_swrst_detect`

## Requirements
- R1: While `rst_n` is low and right after it rises, `ack_req` and `soft_rst` are 0 and the detector is idle, so a STOP alone then produces no pulse.
- R2: After a START, a received byte equal to 00h (general-call address, write) raises `ack_req` in the cycle after `byte_valid`.
- R3: After a START, the byte 01h (general-call address with the read bit, bit 0, set) is not acknowledged, and the following 06h and STOP produce no acknowledge and no pulse.
- R4: After a START, any address byte other than 00h is not acknowledged, and the attempt is abandoned.
- R5: After an acknowledged 00h, a byte equal to 06h is acknowledged. Any other value is not acknowledged, and a later STOP gives no pulse.
- R6: Any byte received after the acknowledged 06h is not acknowledged, and a later STOP gives no pulse.
- R7: A STOP following the acknowledged 06h drives `soft_rst` high for exactly one cycle, the cycle after `bus_stop`.
- R8: A repeated START in place of that STOP produces no pulse and restarts decoding: the next byte is treated as an address.
- R9: `ack_req`, once raised, stays high until it drops in the cycle after `ack_slot_done`, `bus_start` or `bus_stop`.
- R10: When `bus_stop` and `bus_start` arrive in the same cycle on an armed sequence, the pulse is issued and the next byte is treated as an address.
- R11: Asserting `rst_n` low between the acknowledged 06h and the STOP discards the armed sequence: the STOP then gives no pulse.
- R12: A byte received with no START since reset or since the last STOP is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse: START or repeated START seen |
| bus_stop | input | 1 | One-cycle pulse: STOP seen |
| byte_valid | input | 1 | One-cycle pulse: eight bits received |
| byte_data | input | 8 | Received byte, valid with `byte_valid` |
| ack_slot_done | input | 1 | One-cycle pulse: acknowledge slot finished |
| ack_req | output | 1 | Drive ACK (pull SDA low) during the current slot |
| soft_rst | output | 1 | One-cycle software reset pulse to device registers |

## Verification
Two functions can fall in the same cycle: committing the armed reset on STOP, and opening a new transaction on START. A fast bus decoder may report both events together. The bench provokes this on purpose by raising `bus_stop` and `bus_start` in one cycle, both on an armed sequence and on an unarmed one. It then judges that the pulse appears exactly when the sequence was armed, and that the very next byte is decoded as an address. The random phase issues this combined event alongside lone STOPs, STARTs and biased byte values, and a bench reference model predicts each acknowledge and pulse.

// File: rtl/gc_swrst_pkg.sv
package gc_swrst_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Sequence progress of the detector
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,  // no transaction open
    SQ_ADDR  = 3'd1,  // START seen, next byte is an address
    SQ_CMD   = 3'd2,  // general call write acknowledged, awaiting command
    SQ_ARMED = 3'd3,  // command acknowledged, waiting for STOP
    SQ_DEAD  = 3'd4   // attempt abandoned until next START
  } seq_t;

  // Does a received byte earn an acknowledge in the given state?
  function automatic logic byte_earns_ack(seq_t st, byte_t b, byte_t gc_addr, byte_t cmd);
    logic ok;
    ok = 1'b0;
    case (st)
      SQ_ADDR: ok = (b == gc_addr);
      SQ_CMD:  ok = (b == cmd);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // State after a received byte (no START/STOP in the same cycle)
  function automatic seq_t after_byte(seq_t st, byte_t b, byte_t gc_addr, byte_t cmd);
    seq_t nx;
    nx = SQ_DEAD;
    case (st)
      SQ_IDLE: nx = SQ_IDLE;
      SQ_ADDR: nx = (b == gc_addr) ? SQ_CMD : SQ_DEAD;
      SQ_CMD:  nx = (b == cmd) ? SQ_ARMED : SQ_DEAD;
      default: nx = SQ_DEAD;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/gc_seq_fsm.sv
module gc_seq_fsm
  import gc_swrst_pkg::*;
#(
  parameter byte_t GC_ADDR = 8'h00,
  parameter byte_t RST_CMD = 8'h06
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_start,
  input  logic  ev_stop,
  input  logic  ev_byte,
  input  byte_t rx_byte,
  output seq_t  state,
  output logic  armed,
  output logic  byte_accept,
  output logic  commit
);

  seq_t st_q, st_d;
  logic byte_only;

  // a byte is judged only when no framing event shares its cycle
  assign byte_only   = ev_byte && !ev_start && !ev_stop;
  assign byte_accept = byte_only && byte_earns_ack(st_q, rx_byte, GC_ADDR, RST_CMD);
  assign commit      = ev_stop && (st_q == SQ_ARMED);
  assign armed       = (st_q == SQ_ARMED);
  assign state       = st_q;

  always_comb begin
    st_d = st_q;
    if (ev_start)      st_d = SQ_ADDR;   // STOP+START together reopens
    else if (ev_stop)  st_d = SQ_IDLE;
    else if (ev_byte)  st_d = after_byte(st_q, rx_byte, GC_ADDR, RST_CMD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  AST_BYTE_AFTER_ARM_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_only && st_q == SQ_ARMED) |=> (st_q == SQ_DEAD)); // R6
  AST_START_OPENS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st_q == SQ_ADDR)); // R8
  AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE || st_q == SQ_DEAD) |-> !byte_accept); // R12

endmodule

// File: rtl/gc_ack_ctrl.sv
module gc_ack_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic ev_byte,
  input  logic ev_ack_done,
  input  logic byte_accept,
  output logic ack_req
);

  logic ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ack_q <= 1'b0;
    else if (ev_start || ev_stop) ack_q <= 1'b0;
    else if (ev_byte)             ack_q <= byte_accept;
    else if (ev_ack_done)         ack_q <= 1'b0;
  end

  assign ack_req = ack_q;

  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !ev_ack_done && !ev_start && !ev_stop && !ev_byte) |=> ack_q); // R9
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack_done && !ev_byte) |=> !ack_q); // R9

endmodule

// File: rtl/gc_pulse_gen.sv
module gc_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  output logic pulse
);

  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= commit;
  end

  assign pulse = pulse_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R7

endmodule

// File: rtl/gc_swrst_detect.sv
module gc_swrst_detect
  import gc_swrst_pkg::*;
#(
  parameter byte_t GC_ADDR = 8'h00,
  parameter byte_t RST_CMD = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       ack_slot_done,
  output logic       ack_req,
  output logic       soft_rst
);

  // named internal events for the assertions
  seq_t seq_state;
  logic seq_armed;
  logic byte_accept;
  logic commit;

  gc_seq_fsm #(.GC_ADDR(GC_ADDR), .RST_CMD(RST_CMD)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_start    (bus_start),
    .ev_stop     (bus_stop),
    .ev_byte     (byte_valid),
    .rx_byte     (byte_data),
    .state       (seq_state),
    .armed       (seq_armed),
    .byte_accept (byte_accept),
    .commit      (commit)
  );

  gc_ack_ctrl u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_start    (bus_start),
    .ev_stop     (bus_stop),
    .ev_byte     (byte_valid),
    .ev_ack_done (ack_slot_done),
    .byte_accept (byte_accept),
    .ack_req     (ack_req)
  );

  gc_pulse_gen u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .pulse  (soft_rst)
  );

  AST_PULSE_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> $past(bus_stop)); // R7
  AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> $past(seq_armed)); // R7
  AST_ACK_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(byte_valid)); // R2
  AST_ARMED_STOP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_armed && bus_stop) |=> soft_rst); // R10
  AST_ACK_DROP_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> !ack_req); // R9

endmodule

// File: tb/tb_gc_swrst_detect.sv
`timescale 1ns/1ps
module tb_gc_swrst_detect;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0, byte_valid = 1'b0, ack_slot_done = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       ack_req, soft_rst;

  int checks = 0, errors = 0;
  bit done = 0;
  int ms = 0; // model: 0 idle, 1 addr, 2 cmd, 3 armed, 4 dead

  always #2.5 clk = ~clk;

  gc_swrst_detect dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .ack_slot_done(ack_slot_done),
    .ack_req(ack_req), .soft_rst(soft_rst)
  );

  function automatic bit exp_ack(int s, logic [7:0] b);
    return (s == 1 && b == 8'h00) || (s == 2 && b == 8'h06);
  endfunction

  function automatic int exp_next(int s, logic [7:0] b);
    if (s == 0) return 0;
    if (s == 1) return (b == 8'h00) ? 2 : 4;
    if (s == 2) return (b == 8'h06) ? 3 : 4;
    return 4;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    bit e;
    e = exp_ack(ms, b);
    byte_valid = 1'b1; byte_data = b;
    @(negedge clk);
    byte_valid = 1'b0;
    chk(ack_req, e, tag);
    chk(soft_rst, 1'b0, {tag, " no pulse on byte"});
    ms = exp_next(ms, b);
    @(negedge clk);
    chk(ack_req, e, "R9 ack held");
    ack_slot_done = 1'b1;
    @(negedge clk);
    ack_slot_done = 1'b0;
    chk(ack_req, 1'b0, "R9 ack released");
  endtask

  task automatic send_start(input string tag);
    bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
    chk(soft_rst, 1'b0, tag);
    ms = 1;
  endtask

  task automatic send_stop(input bit with_start, input string tag);
    bit e;
    e = (ms == 3);
    bus_stop = 1'b1; bus_start = with_start;
    @(negedge clk);
    bus_stop = 1'b0; bus_start = 1'b0;
    chk(soft_rst, e, tag);
    chk(ack_req, 1'b0, "R9 ack low after frame event");
    ms = with_start ? 1 : 0;
    @(negedge clk);
    chk(soft_rst, 1'b0, "R7 pulse one cycle");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk(ack_req, 1'b0, "R1 ack in reset");
    chk(soft_rst, 1'b0, "R1 pulse in reset");
    @(negedge clk);
    rst_n = 1'b1;
    ms = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    chk(ack_req, 1'b0, "R1 ack after reset");
    send_stop(0, "R1 lone stop no pulse");
    send_byte(8'h00, "R12 byte in idle");
    send_byte(8'h06, "R12 second byte in idle");
    // full valid sequence
    send_start("R2 start");
    send_byte(8'h00, "R2 general call write acked");
    send_byte(8'h06, "R5 command acked");
    send_stop(0, "R7 pulse after stop");
    // read-direction general call
    send_start("R3 start");
    send_byte(8'h01, "R3 read gc not acked");
    send_byte(8'h06, "R3 cmd after read gc");
    send_stop(0, "R3 no pulse");
    // other address
    send_start("R4 start");
    send_byte(8'h42, "R4 other address");
    send_byte(8'h06, "R4 cmd after other address");
    send_stop(0, "R4 no pulse");
    // wrong command
    send_start("R5 start");
    send_byte(8'h00, "R5 addr");
    send_byte(8'h07, "R5 wrong cmd not acked");
    send_byte(8'h06, "R5 later cmd not acked");
    send_stop(0, "R5 no pulse");
    // extra byte
    send_start("R6 start");
    send_byte(8'h00, "R6 addr");
    send_byte(8'h06, "R6 cmd");
    send_byte(8'h06, "R6 surplus not acked");
    send_stop(0, "R6 no pulse");
    // repeated start
    send_start("R8 start");
    send_byte(8'h00, "R8 addr");
    send_byte(8'h06, "R8 cmd");
    send_start("R8 repeated start no pulse");
    chk(soft_rst, 1'b0, "R8 no pulse after rs");
    send_byte(8'h00, "R8 address decoded again");
    send_byte(8'h06, "R8 cmd again");
    send_stop(0, "R8 pulse after proper stop");
    // stop and start coinciding
    send_start("R10 start");
    send_byte(8'h00, "R10 addr");
    send_byte(8'h06, "R10 cmd");
    send_stop(1, "R10 pulse on stop+start");
    send_byte(8'h00, "R10 next byte is address");
    send_byte(8'h06, "R10 cmd acked");
    send_stop(1, "R10 second pulse");
    send_byte(8'h06, "R10 unarmed start reopens: 06 as address");
    send_stop(1, "R10 unarmed no pulse");
    send_stop(0, "R10 close");
    // reset while armed
    send_start("R11 start");
    send_byte(8'h00, "R11 addr");
    send_byte(8'h06, "R11 cmd");
    do_reset();
    send_stop(0, "R11 no pulse after reset");
    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] b;
      op = int'($urandom % 10);
      if (op < 2) send_start("R8 rand start");
      else if (op < 8) begin
        int p;
        p = int'($urandom % 10);
        if (p < 4) b = 8'h00;
        else if (p < 7) b = 8'h06;
        else if (p < 8) b = 8'h01;
        else b = 8'($urandom);
        send_byte(b, "R5 rand byte ack");
      end
      else if (op == 8) send_stop(0, "R7 rand stop");
      else send_stop(1, "R10 rand stop+start");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule